// File: doc/BRIEF.md
# Packed calendar real-time clock

This block is a memory-mapped real-time clock for a control subsystem. Elapsed time is held as one 32-bit packed word. That word carries a running day count and a 24-hour hours:minutes:seconds value. A free-running base tick enters a divide-by-`PRESCALE` stage, which is gated by a run bit. Each terminal count of that stage is one second event, and each second event advances the packed time. The same event decrements a stopwatch counter. It also compares the new time against an alarm word in the same packed layout.

The three event sources raise sticky flags in an interrupt status register, and software clears them by writing ones. A mask register selects which flags drive the interrupt line. Software uses a simple register port. A request is presented for one cycle with `acc_en_i`. The port is always ready and never stalls. Exactly one cycle later `rsp_valid_o` returns the read data and two error flags. Reads return the register contents as they stood before any update in the same cycle.

Top module: `rtc_packed_top`

## Requirements
- R1: The time register at byte offset 0x00 holds seconds in bits 5:0, minutes in bits 11:6, hours in bits 16:12 and the day count in bits 31:17. A legal write loads the written fields at once.
- R2: On a second event, seconds step 59 to 0 and carry into minutes. Minutes step 59 to 0 and carry into hours. Hours step 23 to 0 and carry into the day count. The day count wraps from 0x7FFF to 0.
- R3: A second event occurs on every `PRESCALE`-th base tick, but only while bit 0 of the run register (offset 0x14) is 1. While that bit is 0, ticks change neither the divider nor the time. A time write restarts the divider at zero and cancels any second event in its own cycle.
- R4: Offsets: mask 0x04, status 0x08, stopwatch 0x0C, alarm 0x10, run 0x14. Time and alarm are 32 bits; the others are 16 bits, read zero-extended, and unimplemented bits read 0. A 16-bit access reads or writes only bits 15:0.
- R5: Status bit 0 is the alarm flag, bit 1 the stopwatch flag, and bit 2 the second flag. Writing 1 to any of these bits clears it. A flag set in the same cycle as a clear wins.
- R6: Status bit 14 is set by any time write and cleared by the next second event. No write to the status register clears it.
- R7: When a second event advances the time to a value equal to the alarm word, status bit 0 is set.
- R8: Each second event decrements a nonzero stopwatch by one. A step from 1 to 0 sets status bit 1. A write to the stopwatch loads it and takes priority over a decrement in the same cycle.
- R9: `irq_o` is high exactly when some status bit among 0, 1, 2 and 14 is set together with the same bit of the mask register.
- R10: Size codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit, and only 1 and 2 are legal. Any other size raises `rsp_err_size_o`, has no effect, and returns data 0.
- R11: A legal-size access to an offset outside the six listed offsets raises `rsp_err_addr_o`, has no effect, and returns 0. This includes offsets not on a 4-byte boundary. An access that is both illegal in size and unmapped reports only the size error.
- R12: `rsp_valid_o` follows `acc_en_i` by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Base tick pulse feeding the divider |
| acc_en_i | input | 1 | Register access request, one cycle |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | ADDR_W | Byte offset |
| acc_size_i | input | 2 | Access size code |
| acc_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_rdata_o | output | 32 | Read data |
| rsp_err_size_o | output | 1 | Illegal access size |
| rsp_err_addr_o | output | 1 | Unmapped offset |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench builds the clock with `PRESCALE` = 3 instead of the default 32768, so one second costs three base ticks. Together with direct time loads just below 23:59:59 and just below the top day count, this puts every carry stage and the day wrap within a few dozen cycles. It also lets tests exercise the divider restart at tick granularity. `ADDR_W` stays at 8, which leaves room for probing unmapped offsets beyond 0x14 as well as misaligned ones.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  // packed time layout, seconds in the least significant bits
  typedef struct packed {
    logic [14:0] day;
    logic [4:0]  hr;
    logic [5:0]  min;
    logic [5:0]  sec;
  } rtc_time_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_DBL  = 2'd3;

  localparam int OFF_TIME  = 'h00;
  localparam int OFF_MASK  = 'h04;
  localparam int OFF_STAT  = 'h08;
  localparam int OFF_SWCH  = 'h0C;
  localparam int OFF_ALARM = 'h10;
  localparam int OFF_RUN   = 'h14;

  localparam int ST_ALARM   = 0;
  localparam int ST_SWATCH  = 1;
  localparam int ST_SECOND  = 2;
  localparam int ST_LOADPND = 14;

  localparam logic [HALF_W-1:0] ST_IMPL = 16'h4007;
  localparam logic [HALF_W-1:0] ST_W1C  = 16'h0007;

  function automatic rtc_time_t rtc_step(input rtc_time_t t);
    rtc_time_t r;
    r = t;
    if (t.sec >= 6'd59) begin
      r.sec = '0;
      if (t.min >= 6'd59) begin
        r.min = '0;
        if (t.hr >= 5'd23) begin
          r.hr  = '0;
          r.day = t.day + 15'd1;
        end else begin
          r.hr = t.hr + 5'd1;
        end
      end else begin
        r.min = t.min + 6'd1;
      end
    end else begin
      r.sec = t.sec + 6'd1;
    end
    return r;
  endfunction

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
  parameter int PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic run_i,
  input  logic restart_i,
  output logic sec_evt_o
);

  generate
    if (PRESCALE <= 1) begin : g_direct
      assign sec_evt_o = tick_i && run_i && !restart_i;
    end else begin : g_count
      localparam int CNT_W = $clog2(PRESCALE);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (restart_i) begin
          cnt_q <= '0;
        end else if (tick_i && run_i) begin
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
        end
      end

      assign sec_evt_o = tick_i && run_i && !restart_i && (cnt_q == LAST);

      // R3
      halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !restart_i) |=> $stable(cnt_q));
    end
  endgenerate

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_evt_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] alarm_i,
  output logic [WORD_W-1:0] time_o,
  output logic              alarm_hit_o
);

  rtc_time_t time_q;
  rtc_time_t time_nxt;
  logic      loading;

  assign loading  = wr_lo_i || wr_hi_i;
  assign time_nxt = rtc_step(time_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
    end else if (loading) begin
      if (wr_lo_i) time_q[HALF_W-1:0]      <= wdata_i[HALF_W-1:0];
      if (wr_hi_i) time_q[WORD_W-1:HALF_W] <= wdata_i[WORD_W-1:HALF_W];
    end else if (sec_evt_i) begin
      time_q <= time_nxt;
    end
  end

  assign time_o      = time_q;
  assign alarm_hit_o = sec_evt_i && !loading && (time_nxt == rtc_time_t'(alarm_i));

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt_i && !loading && time_q.sec == 6'd59) |=> (time_q.sec == 6'd0));

  // R2
  hr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt_i && !loading && time_q.sec == 6'd59 && time_q.min == 6'd59 && time_q.hr == 5'd23)
      |=> (time_q.hr == 5'd0 && time_q.day == $past(time_q.day) + 15'd1));

endmodule

// File: rtl/rtc_stopwatch.sv
module rtc_stopwatch
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_evt_i,
  input  logic              wr_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] cnt_o,
  output logic              expire_o
);

  logic [HALF_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_i) begin
      cnt_q <= wdata_i;
    end else if (sec_evt_i && cnt_q != '0) begin
      cnt_q <= cnt_q - HALF_W'(1);
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = sec_evt_i && !wr_i && (cnt_q == HALF_W'(1));

  // R8
  sw_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt_i && !wr_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - HALF_W'(1)));

  // R8
  sw_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_packed_top.sv
module rtc_packed_top
  import rtc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PRESCALE = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              acc_en_i,
  input  logic              acc_we_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [1:0]        acc_size_i,
  input  logic [WORD_W-1:0] acc_wdata_i,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] rsp_rdata_o,
  output logic              rsp_err_size_o,
  output logic              rsp_err_addr_o,
  output logic              irq_o
);

  // ---------------- decode ----------------
  logic size_ok, is_half, mapped, acc_ok, wr_ok;
  logic sel_time, sel_mask, sel_stat, sel_swch, sel_alarm, sel_run;

  assign is_half   = (acc_size_i == SZ_HALF);
  assign size_ok   = is_half || (acc_size_i == SZ_WORD);
  assign sel_time  = (acc_addr_i == ADDR_W'(OFF_TIME));
  assign sel_mask  = (acc_addr_i == ADDR_W'(OFF_MASK));
  assign sel_stat  = (acc_addr_i == ADDR_W'(OFF_STAT));
  assign sel_swch  = (acc_addr_i == ADDR_W'(OFF_SWCH));
  assign sel_alarm = (acc_addr_i == ADDR_W'(OFF_ALARM));
  assign sel_run   = (acc_addr_i == ADDR_W'(OFF_RUN));
  assign mapped    = sel_time || sel_mask || sel_stat || sel_swch || sel_alarm || sel_run;
  assign acc_ok    = acc_en_i && size_ok && mapped;
  assign wr_ok     = acc_ok && acc_we_i;

  logic time_wr, stat_wr, swch_wr, alarm_wr, mask_wr, run_wr;
  assign time_wr  = wr_ok && sel_time;
  assign stat_wr  = wr_ok && sel_stat;
  assign swch_wr  = wr_ok && sel_swch;
  assign alarm_wr = wr_ok && sel_alarm;
  assign mask_wr  = wr_ok && sel_mask;
  assign run_wr   = wr_ok && sel_run;

  // ---------------- registers ----------------
  logic [HALF_W-1:0] mask_q, stat_q, stat_nxt;
  logic [WORD_W-1:0] alarm_q;
  logic              run_q;

  // ---------------- submodules ----------------
  logic              sec_evt, alarm_hit, sw_expire;
  logic [WORD_W-1:0] time_q;
  logic [HALF_W-1:0] sw_cnt;

  rtc_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .run_i     (run_q),
    .restart_i (time_wr),
    .sec_evt_o (sec_evt)
  );

  rtc_timekeeper u_time (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_evt_i   (sec_evt),
    .wr_lo_i     (time_wr),
    .wr_hi_i     (time_wr && !is_half),
    .wdata_i     (acc_wdata_i),
    .alarm_i     (alarm_q),
    .time_o      (time_q),
    .alarm_hit_o (alarm_hit)
  );

  rtc_stopwatch u_sw (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_evt_i (sec_evt),
    .wr_i      (swch_wr),
    .wdata_i   (acc_wdata_i[HALF_W-1:0]),
    .cnt_o     (sw_cnt),
    .expire_o  (sw_expire)
  );

  // ---------------- status next state ----------------
  always_comb begin
    stat_nxt = stat_q;
    if (stat_wr) stat_nxt = stat_nxt & ~(acc_wdata_i[HALF_W-1:0] & ST_W1C);
    if (sec_evt)   stat_nxt[ST_LOADPND] = 1'b0;
    if (time_wr)   stat_nxt[ST_LOADPND] = 1'b1;
    if (sec_evt)   stat_nxt[ST_SECOND]  = 1'b1;
    if (alarm_hit) stat_nxt[ST_ALARM]   = 1'b1;
    if (sw_expire) stat_nxt[ST_SWATCH]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      stat_q  <= '0;
      alarm_q <= '0;
      run_q   <= 1'b0;
    end else begin
      stat_q <= stat_nxt & ST_IMPL;
      if (mask_wr) mask_q <= acc_wdata_i[HALF_W-1:0] & ST_IMPL;
      if (run_wr)  run_q  <= acc_wdata_i[0];
      if (alarm_wr) begin
        alarm_q[HALF_W-1:0] <= acc_wdata_i[HALF_W-1:0];
        if (!is_half) alarm_q[WORD_W-1:HALF_W] <= acc_wdata_i[WORD_W-1:HALF_W];
      end
    end
  end

  // ---------------- read path and response ----------------
  logic [WORD_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    if (sel_time)       rd_word = time_q;
    else if (sel_mask)  rd_word = {{(WORD_W-HALF_W){1'b0}}, mask_q};
    else if (sel_stat)  rd_word = {{(WORD_W-HALF_W){1'b0}}, stat_q};
    else if (sel_swch)  rd_word = {{(WORD_W-HALF_W){1'b0}}, sw_cnt};
    else if (sel_alarm) rd_word = alarm_q;
    else if (sel_run)   rd_word = {{(WORD_W-1){1'b0}}, run_q};
    if (is_half) rd_word[WORD_W-1:HALF_W] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o    <= 1'b0;
      rsp_rdata_o    <= '0;
      rsp_err_size_o <= 1'b0;
      rsp_err_addr_o <= 1'b0;
    end else begin
      rsp_valid_o    <= acc_en_i;
      rsp_rdata_o    <= (acc_ok && !acc_we_i) ? rd_word : '0;
      rsp_err_size_o <= acc_en_i && !size_ok;
      rsp_err_addr_o <= acc_en_i && size_ok && !mapped;
    end
  end

  assign irq_o = |(stat_q & mask_q);

  // ---------------- assertions ----------------
  // R12
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en_i |=> rsp_valid_o);

  // R11
  size_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en_i && (acc_size_i == SZ_BYTE || acc_size_i == SZ_DBL))
      |=> (rsp_err_size_o && !rsp_err_addr_o && rsp_rdata_o == '0));

  // R6
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[ST_LOADPND] && !sec_evt) |=> stat_q[ST_LOADPND]);

  // R5
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && acc_wdata_i[ST_ALARM] && !alarm_hit) |=> !stat_q[ST_ALARM]);

  // R3
  frozen_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !time_wr) |=> $stable(time_q));

endmodule

// File: tb/tb_rtc_packed_top.sv
module tb_rtc_packed_top;

  localparam int P  = 3;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        acc_en_i = 1'b0;
  logic        acc_we_i = 1'b0;
  logic [7:0]  acc_addr_i = '0;
  logic [1:0]  acc_size_i = '0;
  logic [31:0] acc_wdata_i = '0;
  logic        rsp_valid_o, rsp_err_size_o, rsp_err_addr_o, irq_o;
  logic [31:0] rsp_rdata_o;

  rtc_packed_top #(.ADDR_W(AW), .PRESCALE(P)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .acc_en_i(acc_en_i), .acc_we_i(acc_we_i), .acc_addr_i(acc_addr_i),
    .acc_size_i(acc_size_i), .acc_wdata_i(acc_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .rsp_err_size_o(rsp_err_size_o), .rsp_err_addr_o(rsp_err_addr_o),
    .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pk(input int d, input int h, input int m, input int s);
    return (32'(d) << 17) | (32'(h) << 12) | (32'(m) << 6) | 32'(s);
  endfunction

  // advance by total-seconds arithmetic, wrapping over the whole day range
  function automatic logic [31:0] plus_one(input logic [31:0] t);
    longint tot;
    longint span;
    span = 64'd32768 * 64'd86400;
    tot = longint'(t[31:17]) * 86400 + longint'(t[16:12]) * 3600
        + longint'(t[11:6]) * 60 + longint'(t[5:0]) + 1;
    tot = tot % span;
    return pk(int'(tot / 86400), int'((tot % 86400) / 3600),
              int'((tot % 3600) / 60), int'(tot % 60));
  endfunction

  // ---------------- reference model ----------------
  logic [31:0] m_time = '0, m_alarm = '0, m_rd = '0;
  logic [15:0] m_mask = '0, m_stat = '0, m_sw = '0;
  logic        m_run = 1'b0, m_rv = 1'b0, m_es = 1'b0, m_ea = 1'b0;
  int          m_pre = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_time = '0; m_alarm = '0; m_mask = '0; m_stat = '0; m_sw = '0;
      m_run = 1'b0; m_pre = 0; m_rv = 1'b0; m_rd = '0; m_es = 1'b0; m_ea = 1'b0;
    end else begin
      bit sz_ok, mp, ok, twr, sec;
      int off;
      logic [31:0] rv, nt;
      logic [15:0] ns;
      off   = int'(acc_addr_i);
      sz_ok = (acc_size_i == 2'd1) || (acc_size_i == 2'd2);
      mp    = (off == 0) || (off == 4) || (off == 8) || (off == 12) || (off == 16) || (off == 20);
      ok    = acc_en_i && sz_ok && mp;
      rv = '0;
      if (ok && !acc_we_i) begin
        case (off)
          0:  rv = m_time;
          4:  rv = {16'h0, m_mask};
          8:  rv = {16'h0, m_stat};
          12: rv = {16'h0, m_sw};
          16: rv = m_alarm;
          default: rv = {31'h0, m_run};
        endcase
        if (acc_size_i == 2'd1) rv = rv & 32'h0000_FFFF;
      end
      m_rv = acc_en_i; m_rd = rv;
      m_es = acc_en_i && !sz_ok;
      m_ea = acc_en_i && sz_ok && !mp;
      twr  = ok && acc_we_i && off == 0;
      sec  = 1'b0;
      if (twr) m_pre = 0;
      else if (tick_i && m_run) begin
        if (m_pre == P - 1) begin sec = 1'b1; m_pre = 0; end
        else m_pre++;
      end
      ns = m_stat;
      if (ok && acc_we_i && off == 8) ns = ns & ~(acc_wdata_i[15:0] & 16'h0007);
      if (sec) ns[14] = 1'b0;
      if (twr) ns[14] = 1'b1;
      if (sec) begin
        nt = plus_one(m_time);
        if (nt == m_alarm) ns[0] = 1'b1;
        ns[2] = 1'b1;
        m_time = nt;
      end
      if (twr) begin
        if (acc_size_i == 2'd2) m_time = acc_wdata_i;
        else m_time[15:0] = acc_wdata_i[15:0];
      end
      if (ok && acc_we_i && off == 12) m_sw = acc_wdata_i[15:0];
      else if (sec && m_sw != 0) begin
        if (m_sw == 16'd1) ns[1] = 1'b1;
        m_sw = m_sw - 16'd1;
      end
      if (ok && acc_we_i && off == 4) m_mask = acc_wdata_i[15:0] & 16'h4007;
      if (ok && acc_we_i && off == 20) m_run = acc_wdata_i[0];
      if (ok && acc_we_i && off == 16) begin
        m_alarm[15:0] = acc_wdata_i[15:0];
        if (acc_size_i == 2'd2) m_alarm[31:16] = acc_wdata_i[31:16];
      end
      m_stat = ns;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R12 rsp_valid vs model", {31'h0, rsp_valid_o}, {31'h0, m_rv});
      if (m_rv) begin
        chk("R10/R11 rdata vs model", rsp_rdata_o, m_rd);
        chk("R10 err_size vs model", {31'h0, rsp_err_size_o}, {31'h0, m_es});
        chk("R11 err_addr vs model", {31'h0, rsp_err_addr_o}, {31'h0, m_ea});
      end
      chk("R9 irq vs model", {31'h0, irq_o}, {31'h0, |(m_stat & m_mask)});
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic bus_wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    acc_en_i = 1'b1; acc_we_i = 1'b1; acc_addr_i = a; acc_size_i = sz; acc_wdata_i = d;
    @(negedge clk);
    acc_en_i = 1'b0; acc_we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] exp,
                        input string tag);
    @(negedge clk);
    acc_en_i = 1'b1; acc_we_i = 1'b0; acc_addr_i = a; acc_size_i = sz;
    @(negedge clk);
    acc_en_i = 1'b0;
    chk(tag, rsp_rdata_o, exp);
  endtask

  task automatic bus_probe(input logic [7:0] a, input logic [1:0] sz, input logic we,
                           input logic es, input logic ea, input string tag);
    @(negedge clk);
    acc_en_i = 1'b1; acc_we_i = we; acc_addr_i = a; acc_size_i = sz; acc_wdata_i = 32'hFFFF_FFFF;
    @(negedge clk);
    acc_en_i = 1'b0; acc_we_i = 1'b0;
    chk(tag, {29'h0, rsp_err_size_o, rsp_err_addr_o, rsp_valid_o}, {29'h0, es, ea, 1'b1});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // ---------------- sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 irq after reset", {31'h0, irq_o}, 32'h0);
    bus_rd(8'h00, 2'd2, 32'h0, "R1 time after reset");
    bus_rd(8'h08, 2'd2, 32'h0, "R5 status after reset");

    bus_wr(8'h14, 2'd2, 32'h1);
    bus_wr(8'h04, 2'd2, 32'h3);
    bus_wr(8'h00, 2'd2, pk(0, 23, 59, 58));
    bus_rd(8'h00, 2'd2, pk(0, 23, 59, 58), "R1 time load");
    bus_rd(8'h08, 2'd2, 32'h4000, "R6 pending set by time write");
    bus_wr(8'h08, 2'd2, 32'hFFFF);
    bus_rd(8'h08, 2'd2, 32'h4000, "R6 pending survives W1C");
    ticks(3);
    bus_rd(8'h00, 2'd2, pk(0, 23, 59, 59), "R3 one second after three ticks");
    bus_rd(8'h08, 2'd2, 32'h0004, "R6 pending cleared, R5 second flag");
    ticks(3);
    bus_rd(8'h00, 2'd2, pk(1, 0, 0, 0), "R2 carry into day");
    bus_wr(8'h08, 2'd2, 32'h4);
    bus_rd(8'h08, 2'd2, 32'h0, "R5 W1C clears second flag");

    bus_wr(8'h14, 2'd2, 32'h0);
    ticks(6);
    bus_rd(8'h00, 2'd2, pk(1, 0, 0, 0), "R3 halted while run bit clear");
    bus_wr(8'h14, 2'd2, 32'h1);
    ticks(2);
    bus_wr(8'h00, 2'd2, pk(2, 5, 6, 7));
    ticks(2);
    bus_rd(8'h00, 2'd2, pk(2, 5, 6, 7), "R3 divider restarted by time write");
    ticks(1);
    bus_rd(8'h00, 2'd2, pk(2, 5, 6, 8), "R3 third tick after restart");

    bus_wr(8'h10, 2'd2, pk(0, 0, 0, 2));
    bus_wr(8'h00, 2'd2, pk(32767, 23, 59, 59));
    ticks(3);
    bus_rd(8'h00, 2'd2, 32'h0, "R2 day count wraps to zero");
    bus_wr(8'h08, 2'd2, 32'h7);
    chk("R9 irq low with second flag masked", {31'h0, irq_o}, 32'h0);
    ticks(6);
    chk("R7 R9 irq from alarm", {31'h0, irq_o}, 32'h1);
    bus_rd(8'h08, 2'd2, 32'h0005, "R7 alarm flag set");
    bus_wr(8'h08, 2'd2, 32'h1);
    bus_rd(8'h08, 2'd2, 32'h0004, "R5 alarm flag cleared");

    bus_wr(8'h0C, 2'd1, 32'h2);
    ticks(3);
    bus_rd(8'h0C, 2'd1, 32'h1, "R8 stopwatch decrement");
    ticks(3);
    bus_rd(8'h0C, 2'd1, 32'h0, "R8 stopwatch reaches zero");
    chk("R8 R9 irq from stopwatch", {31'h0, irq_o}, 32'h1);
    bus_rd(8'h08, 2'd2, 32'h0006, "R8 stopwatch flag");
    bus_wr(8'h08, 2'd2, 32'h7);
    ticks(3);
    bus_rd(8'h08, 2'd2, 32'h0004, "R8 no flag when idle at zero");

    bus_wr(8'h10, 2'd2, 32'hABCD_0002);
    bus_wr(8'h10, 2'd1, 32'h5555_1234);
    bus_rd(8'h10, 2'd2, 32'hABCD_1234, "R4 half write keeps upper alarm");
    bus_rd(8'h10, 2'd1, 32'h0000_1234, "R4 half read of alarm");
    bus_rd(8'h14, 2'd2, 32'h1, "R4 run register read");
    bus_wr(8'h04, 2'd2, 32'hFFFF_FFFF);
    bus_rd(8'h04, 2'd2, 32'h4007, "R4 unimplemented mask bits read zero");

    bus_probe(8'h00, 2'd0, 1'b0, 1'b1, 1'b0, "R10 byte read rejected");
    bus_probe(8'h04, 2'd3, 1'b1, 1'b1, 1'b0, "R10 wide write rejected");
    bus_rd(8'h04, 2'd2, 32'h4007, "R10 rejected write had no effect");
    bus_probe(8'h14, 2'd0, 1'b1, 1'b1, 1'b0, "R10 byte write rejected");
    bus_rd(8'h14, 2'd2, 32'h1, "R10 run bit untouched");
    bus_probe(8'h18, 2'd2, 1'b0, 1'b0, 1'b1, "R11 unmapped offset");
    bus_probe(8'h02, 2'd1, 1'b1, 1'b0, 1'b1, "R11 misaligned offset");
    bus_probe(8'h18, 2'd0, 1'b0, 1'b1, 1'b0, "R11 size error wins");
    bus_rd(8'h00, 2'd2, plus_one(m_time) & 32'h0 | m_time, "R1 time unchanged by rejected accesses");

    bus_wr(8'h04, 2'd2, 32'h4000);
    bus_wr(8'h08, 2'd2, 32'h7);
    chk("R9 irq low before load", {31'h0, irq_o}, 32'h0);
    bus_wr(8'h00, 2'd1, 32'h0000_0005);
    chk("R6 R9 irq from pending bit", {31'h0, irq_o}, 32'h1);
    ticks(3);
    chk("R6 pending cleared by second event", {31'h0, irq_o}, 32'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule